// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock waveform for an I2C master. The module clock first passes through a programmable prescaler, which emits a one-cycle tick every (prescale + 1) module clocks. A phase counter then counts those ticks to time the low and high halves of the clock. Each half is as long as its programmed length plus a fixed offset, and the offset depends on the prescale value. Software would choose a prescale value that puts the tick rate between roughly 7 and 12 MHz.

The block has one small register write port. Three configuration registers hold the prescale value, the low length and the high length. A mode register holds a run bit. While the run bit is clear, the counters are held at zero, the clock line is released and the configuration registers accept writes. Once the run bit is set, the block drives the low half first and then alternates between low and high for as long as the run bit stays set. The bus engine receives the prescaled tick as a timing reference.

Top module: `i2cSclTimer`

## Requirements
- R1: After reset, and in any cycle while the run bit is clear, `sclLowReq` and `presTick` are both 0. All registers reset to 0.
- R2: While running, `presTick` is 1 in run-cycle k (k = 0 is the first cycle with the run bit set) exactly when k mod (P+1) equals P, where P is the prescale value.
- R3: The phase offset d is 7 when P is 0, 6 when P is 1, and 5 when P is 2 or more.
- R4: The low half comes first. `sclLowReq` is 1 from run-cycle 0 for (CL+d)*(P+1) cycles, where CL is the low-length register.
- R5: Each low half is followed by a high half of (CH+d)*(P+1) cycles with `sclLowReq` at 0, where CH is the high-length register. The halves alternate with period (P+1)*(CL+CH+2d), and the level changes only in the cycle after a tick.
- R6: A write to the prescale, low-length or high-length register while the run bit is set is ignored. This is visible after a stop and restart, because the old timing is still in use.
- R7: Clearing the run bit releases the clock line and clears both counters in the next cycle. A later restart begins with a complete low half.
- R8: The `regSel` encoding is 0 for prescale (low PSC_W bits of data), 1 for low length, 2 for high length, and 3 for mode, where data bit 0 is the run bit. Mode writes are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (see R8) |
| regWrData | input | DIV_W | Write data |
| sclLowReq | output | 1 | Request to pull the clock line low |
| presTick | output | 1 | One-cycle prescaled tick |

## Verification
A mode write presented in one cycle is captured at the next edge. Its effect therefore appears in the following cycle, which the bench treats as run-cycle 0 for both outputs. Both outputs depend combinationally on registered state, so no further latency is added. The bench drives inputs and samples outputs on the falling edge. At each sample it compares both outputs against a cycle-indexed model built from P, CL, CH and d, over two full periods per configuration. Ignored writes are injected at a known run-cycle and then judged through the timing seen after a restart.

// File: rtl/sclTimingPkg.sv
package sclTimingPkg;

  typedef struct packed {
    logic runEn;
    logic phaseHigh;
  } sclCmd_t;

  typedef enum logic [1:0] {
    SEL_PSC  = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_MODE = 2'd3
  } regSel_e;

  // Fixed per-phase offset chosen from the prescale value.
  function automatic int unsigned phaseOffset(input int unsigned psc);
    if (psc == 0) return 7;
    else if (psc == 1) return 6;
    else return 5;
  endfunction

endpackage

// File: rtl/sclTimerCtrl.sv
module sclTimerCtrl
  import sclTimingPkg::*;
#(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [DIV_W-1:0] wrData,
  input  logic             phaseDone,
  output sclCmd_t          cmd,
  output logic [PSC_W-1:0] pscVal,
  output logic [CNT_W-1:0] phaseLen
);

  logic [PSC_W-1:0] pscReg;
  logic [DIV_W-1:0] lowReg;
  logic [DIV_W-1:0] highReg;
  logic             runReg;
  logic             highPhase;
  logic             cfgWrOk;

  // configuration only changes while stopped
  assign cfgWrOk = wrEn && !runReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscReg  <= '0;
      lowReg  <= '0;
      highReg <= '0;
      runReg  <= 1'b0;
    end else begin
      if (cfgWrOk && wrSel == SEL_PSC)  pscReg  <= wrData[PSC_W-1:0];
      if (cfgWrOk && wrSel == SEL_LOW)  lowReg  <= wrData;
      if (cfgWrOk && wrSel == SEL_HIGH) highReg <= wrData;
      if (wrEn && wrSel == SEL_MODE)    runReg  <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              highPhase <= 1'b0;
    else if (!runReg)       highPhase <= 1'b0;
    else if (phaseDone)     highPhase <= !highPhase;
  end

  always_comb begin
    phaseLen = CNT_W'(highPhase ? highReg : lowReg)
             + CNT_W'(phaseOffset(32'(pscReg)));
  end

  assign cmd.runEn     = runReg;
  assign cmd.phaseHigh = highPhase;
  assign pscVal        = pscReg;

endmodule

// File: rtl/sclTimerDatapath.sv
module sclTimerDatapath
  import sclTimingPkg::*;
#(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclCmd_t          cmd,
  input  logic [PSC_W-1:0] pscVal,
  input  logic [CNT_W-1:0] phaseLen,
  output logic             tick,
  output logic             phaseDone
);

  logic [PSC_W-1:0] preCnt;
  logic [CNT_W-1:0] phaseCnt;

  assign tick      = cmd.runEn && (preCnt == pscVal);
  assign phaseDone = tick && (phaseCnt == phaseLen - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preCnt <= '0;
    else if (!cmd.runEn)  preCnt <= '0;
    else if (tick)        preCnt <= '0;
    else                  preCnt <= preCnt + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       phaseCnt <= '0;
    else if (!cmd.runEn || phaseDone) phaseCnt <= '0;
    else if (tick)                   phaseCnt <= phaseCnt + CNT_W'(1);
  end

endmodule

// File: rtl/i2cSclTimer.sv
module i2cSclTimer
  import sclTimingPkg::*;
#(
  parameter int PSC_W = 8,
  parameter int DIV_W = 16,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [DIV_W-1:0] regWrData,
  output logic             sclLowReq,
  output logic             presTick
);

  sclCmd_t          ctrlCmd;
  logic [PSC_W-1:0] pscVal;
  logic [CNT_W-1:0] phaseLen;
  logic             tick;
  logic             phaseDone;
  logic             runActive;

  sclTimerCtrl #(.PSC_W(PSC_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrSel(regSel),
    .wrData(regWrData), .phaseDone(phaseDone), .cmd(ctrlCmd),
    .pscVal(pscVal), .phaseLen(phaseLen)
  );

  sclTimerDatapath #(.PSC_W(PSC_W), .DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(ctrlCmd), .pscVal(pscVal),
    .phaseLen(phaseLen), .tick(tick), .phaseDone(phaseDone)
  );

  assign runActive = ctrlCmd.runEn;
  assign sclLowReq = ctrlCmd.runEn && !ctrlCmd.phaseHigh;
  assign presTick  = tick;

endmodule

// File: rtl/i2cSclTimerChk.sv
module i2cSclTimerChk #(
  parameter int PSC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             runActive,
  input logic [PSC_W-1:0] pscVal,
  input logic             sclLowReq,
  input logic             presTick
);

  p_stopped_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !runActive |-> (!sclLowReq && !presTick));

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (presTick && pscVal != '0) |=> !presTick);

  p_low_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runActive) |-> sclLowReq);

  p_edge_after_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (runActive && $past(runActive) && sclLowReq != $past(sclLowReq))
      |-> $past(presTick));

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    runActive |=> $stable(pscVal));

endmodule

bind i2cSclTimer i2cSclTimerChk #(.PSC_W(PSC_W)) uChk (
  .clk(clk), .rstN(rstN), .runActive(runActive), .pscVal(pscVal),
  .sclLowReq(sclLowReq), .presTick(presTick)
);

// File: tb/tb_i2cSclTimer.sv
module tb_i2cSclTimer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [DIV_W-1:0] regWrData = '0;
  logic sclLowReq, presTick;
  int checks = 0;
  int errors = 0;

  i2cSclTimer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .sclLowReq(sclLowReq), .presTick(presTick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int offsetOf(int p);  // R3
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  function automatic logic expLow(int k, int p, int l, int h);
    int d = offsetOf(p);
    int per = (p + 1) * (l + h + 2 * d);
    return (k % per) < (p + 1) * (l + d);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int sel, int data);
    regWrEn = 1'b1; regSel = 2'(sel); regWrData = DIV_W'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkStopped(int n);
    for (int i = 0; i < n; i++) begin
      check("R1/R7 scl", sclLowReq, 1'b0);
      check("R1/R7 tick", presTick, 1'b0);
      @(negedge clk);
    end
  endtask

  // Runs two periods from run-cycle 0; optional ignored write at injAt (R6)
  task automatic runCheck(int p, int l, int h, int injAt, int injSel, int injVal);
    int per = (p + 1) * (l + h + 2 * offsetOf(p));
    wr(3, 1);  // R8 mode run
    for (int k = 0; k < 2 * per; k++) begin
      check("R4/R5 scl", sclLowReq, expLow(k, p, l, h));
      check("R2 tick", presTick, (k % (p + 1)) == p);
      if (k == injAt) begin
        regWrEn = 1'b1; regSel = 2'(injSel); regWrData = DIV_W'(injVal);
      end else regWrEn = 1'b0;
      @(negedge clk);
    end
    regWrEn = 1'b0;
    wr(3, 0);
    checkStopped(3);
  endtask

  task automatic config3(int p, int l, int h);
    wr(0, p); wr(1, l); wr(2, h);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    checkStopped(2);  // R1 in reset
    rstN = 1'b1;
    @(negedge clk);
    checkStopped(4);  // R1 after reset

    runCheck(0, 0, 0, -1, 0, 0);  // reset defaults, R3 d=7
    config3(1, 2, 3); runCheck(1, 2, 3, -1, 0, 0);  // R3 d=6
    config3(2, 0, 1); runCheck(2, 0, 1, -1, 0, 0);  // R3 d=5
    config3(5, 1, 0); runCheck(5, 1, 0, -1, 0, 0);

    for (int i = 0; i < 12; i++) begin
      int p = int'($urandom_range(4, 0));
      int l = int'($urandom_range(9, 0));
      int h = int'($urandom_range(9, 0));
      config3(p, l, h);
      runCheck(p, l, h, -1, 0, 0);
    end

    // R6: writes while running are ignored, visible after restart
    config3(1, 3, 2);
    runCheck(1, 3, 2, 4, 1, 20);
    runCheck(1, 3, 2, 7, 0, 3);
    runCheck(1, 3, 2, 2, 2, 9);

    // R7: stop mid-phase, restart starts full low half
    config3(0, 4, 4);
    wr(3, 1);
    repeat (15) @(negedge clk);
    wr(3, 0);
    checkStopped(5);
    runCheck(0, 4, 4, -1, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule